// File: doc/BRIEF.md
# Multidrop Serial Receiver with Mute Wakeup

This block receives asynchronous serial frames (one start bit, eight data bits sent least significant bit first, one stop bit) from a single input line, using a 16x oversampling tick from an external rate generator. It is intended for a multi-drop link where many nodes share one line. A node that is not addressed can put itself into a mute state. While muted, the receiver silently throws away every frame until a wake condition brings it back.

Two wake methods are selectable. The first is a stretch of quiet line lasting one frame time. The second is an address-mark frame, which is a frame whose most significant data bit is 1. Whether a byte is kept is decided at the stop-bit sample, using the mute bit as it stands at that moment. A wake caused by an address mark clears the mute bit before that point, so the address byte itself is received.

A small register port exposes a control register, a status register and a data register. A shadow flag protects the mute bit against a read-modify-write that was started before the hardware cleared it.

Top module: `mute_uart_rx`

## Requirements
- R1: After a falling edge on the idle line, the receiver samples the line again 8 oversample ticks later. If the line is high at that sample, the edge is treated as noise and no frame is produced.
- R2: Register addresses are control = 0, status = 1 and data = 2. A frame that ends with the mute bit at 0 and the receiver enabled has its byte (LSB first) loaded into the data register, and status bit 0 (data ready) is set at the stop-bit sample. The `irq` output is high while data ready and control bit 3 (interrupt enable) are both 1.
- R3: A read of the data register clears data ready.
- R4: Status bit 1 holds the stop-bit sample result of the last frame that was accepted: 1 means the stop sample was low. It changes only when a frame is accepted.
- R5: Writing 1 to control bit 0 (mute) enters mute. A frame whose stop-bit sample finds mute at 1 loads no data and leaves data ready clear.
- R6: A software write of 0 to control bit 0 leaves mute, and the next frame is received.
- R7: With control bit 1 set to 1 (address-mark wake), a muted receiver drops frames whose bit 7 is 0. A frame whose bit 7 is 1 clears mute and is itself received.
- R8: With control bit 1 set to 0 (idle wake), a muted receiver leaves mute once the line has stayed high with no frame in progress for IDLE_BITS×OSR ticks (160 by default). Shorter gaps and address-mark frames do not wake it. The frame after the wake is received.
- R9: After the hardware clears mute, a control write carrying mute = 1 leaves mute at 0, while its other bits still take effect. This holds until the control register is read. After that read, such a write sets mute again.
- R10: While control bit 2 (receiver enable) is 0, line activity produces no frame and sets no flag.
- R11: After reset, the control register reads 0, the status register reads 0 and `irq` is low.
- R12: Control bits 4 and 5 (transmit enable, send break) are stored and read back, and they have no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| reg_addr | input | 2 | Register select (0 control, 1 status, 2 data) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; its side effects take place on this cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Data-ready interrupt |

## Verification
The bound checker watches several things on every cycle. It checks that a frame ending while muted leaves the data register and the ready flag untouched, and that an unmuted frame end always raises ready. It checks that a data read drops ready, that the mute bit falls only through a control write or a wake event, that a blocked re-arm keeps mute low, and that the error flag moves only on accepted frames. Some behaviour can only be shown by the bench's scenarios, because it depends on real line timing over whole frames. This covers noise rejection on the start bit, the exact byte recovered from the line, address-mark versus idle wake selection, the length of the idle gap needed to wake, and the stale read-modify-write sequence.

// File: rtl/muterx_pkg.sv
package muterx_pkg;
   localparam int unsigned REG_W = 8;

   typedef enum logic [1:0] {
      ADR_CTRL = 2'd0,
      ADR_STAT = 2'd1,
      ADR_DATA = 2'd2
   } reg_addr_e;

   // control register bit positions
   localparam int unsigned CB_MUTE  = 0;
   localparam int unsigned CB_WADDR = 1;
   localparam int unsigned CB_RXEN  = 2;
   localparam int unsigned CB_IE    = 3;
   localparam int unsigned CB_TXEN  = 4;
   localparam int unsigned CB_BRK   = 5;

   // status register bit positions
   localparam int unsigned SB_READY = 0;
   localparam int unsigned SB_FERR  = 1;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_e;
endpackage

// File: rtl/muterx_frame.sv
module muterx_frame #(
   parameter int unsigned OSR         = 16,
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 enable,
   input  logic                 rxd,
   output logic                 line,
   output logic                 rx_idle,
   output logic                 mark_evt,
   output logic                 frame_done,
   output logic                 stop_ok,
   output logic [DATA_BITS-1:0] data
);
   import muterx_pkg::*;

   localparam int unsigned CW = $clog2(OSR);
   localparam int unsigned IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam logic [CW-1:0] BIT_LAST  = CW'(OSR - 1);
   localparam logic [CW-1:0] HALF_LAST = CW'(OSR / 2 - 1);
   localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

   logic [SYNC_STAGES-1:0] sync_q;

   genvar g;
   generate
      for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[g] <= 1'b1;
               else        sync_q[g] <= rxd;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[g] <= 1'b1;
               else        sync_q[g] <= sync_q[g-1];
         end
      end
   endgenerate

   assign line = sync_q[SYNC_STAGES-1];

   rx_state_e      st_q;
   logic [CW-1:0]  cnt_q;
   logic [IW-1:0]  idx_q;

   assign rx_idle = (st_q == RX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= RX_IDLE;
         cnt_q      <= '0;
         idx_q      <= '0;
         data       <= '0;
         mark_evt   <= 1'b0;
         frame_done <= 1'b0;
         stop_ok    <= 1'b1;
      end else begin
         mark_evt   <= 1'b0;
         frame_done <= 1'b0;
         if (!enable) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
         end else if (tick) begin
            unique case (st_q)
               RX_IDLE: if (!line) begin
                  st_q  <= RX_START;
                  cnt_q <= '0;
               end
               RX_START: begin
                  if (cnt_q == HALF_LAST) begin
                     cnt_q <= '0;
                     idx_q <= '0;
                     st_q  <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt_q == BIT_LAST) begin
                     cnt_q <= '0;
                     data  <= {line, data[DATA_BITS-1:1]};
                     if (idx_q == IDX_LAST) begin
                        st_q     <= RX_STOP;
                        mark_evt <= line;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt_q == BIT_LAST) begin
                     cnt_q      <= '0;
                     st_q       <= RX_IDLE;
                     frame_done <= 1'b1;
                     stop_ok    <= line;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/muterx_idle.sv
module muterx_idle #(
   parameter int unsigned OSR       = 16,
   parameter int unsigned IDLE_BITS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic enable,
   input  logic line,
   input  logic rx_idle,
   output logic wake
);
   localparam int unsigned LIMIT = OSR * IDLE_BITS;
   localparam int unsigned RW    = $clog2(LIMIT + 1);
   localparam logic [RW-1:0] RUN_MAX  = RW'(LIMIT);
   localparam logic [RW-1:0] RUN_LAST = RW'(LIMIT - 1);

   logic [RW-1:0] run_q;
   logic          quiet;

   assign quiet = enable && line && rx_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         wake  <= 1'b0;
      end else begin
         wake <= quiet && tick && (run_q == RUN_LAST);
         if (!quiet)                         run_q <= '0;
         else if (tick && run_q != RUN_MAX)  run_q <= run_q + 1'b1;
      end
   end
endmodule

// File: rtl/muterx_regs.sv
module muterx_regs #(
   parameter int unsigned DATA_BITS = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [1:0]                     addr,
   input  logic                           wr_en,
   input  logic                           rd_en,
   input  logic [muterx_pkg::REG_W-1:0]   wdata,
   output logic [muterx_pkg::REG_W-1:0]   rdata,
   input  logic                           frame_done,
   input  logic                           frame_stop_ok,
   input  logic [DATA_BITS-1:0]           frame_data,
   input  logic                           mark_evt,
   input  logic                           idle_evt,
   output logic                           mute,
   output logic                           rx_en,
   output logic                           ie,
   output logic                           ready,
   output logic                           ferr,
   output logic                           hw_clr,
   output logic                           hw_wake,
   output logic [DATA_BITS-1:0]           data_q
);
   import muterx_pkg::*;

   logic waddr_q, txen_q, brk_q;
   logic ctrl_wr, ctrl_rd, data_rd, accept;

   assign ctrl_wr = wr_en && (addr == ADR_CTRL);
   assign ctrl_rd = rd_en && (addr == ADR_CTRL);
   assign data_rd = rd_en && (addr == ADR_DATA);
   assign hw_wake = mute && (waddr_q ? mark_evt : idle_evt);
   assign accept  = frame_done && !mute;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mute    <= 1'b0;
         waddr_q <= 1'b0;
         rx_en   <= 1'b0;
         ie      <= 1'b0;
         txen_q  <= 1'b0;
         brk_q   <= 1'b0;
         hw_clr  <= 1'b0;
         ready   <= 1'b0;
         ferr    <= 1'b0;
         data_q  <= '0;
      end else begin
         if (ctrl_wr) begin
            waddr_q <= wdata[CB_WADDR];
            rx_en   <= wdata[CB_RXEN];
            ie      <= wdata[CB_IE];
            txen_q  <= wdata[CB_TXEN];
            brk_q   <= wdata[CB_BRK];
         end
         if (hw_wake)
            mute <= 1'b0;
         else if (ctrl_wr && !(wdata[CB_MUTE] && hw_clr))
            mute <= wdata[CB_MUTE];

         if (hw_wake)      hw_clr <= 1'b1;
         else if (ctrl_rd) hw_clr <= 1'b0;

         if (accept) begin
            ready  <= 1'b1;
            ferr   <= !frame_stop_ok;
            data_q <= frame_data;
         end else if (data_rd) begin
            ready <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         ADR_CTRL: begin
            rdata[CB_MUTE]  = mute;
            rdata[CB_WADDR] = waddr_q;
            rdata[CB_RXEN]  = rx_en;
            rdata[CB_IE]    = ie;
            rdata[CB_TXEN]  = txen_q;
            rdata[CB_BRK]   = brk_q;
         end
         ADR_STAT: begin
            rdata[SB_READY] = ready;
            rdata[SB_FERR]  = ferr;
         end
         ADR_DATA: rdata[DATA_BITS-1:0] = data_q;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/mute_uart_rx.sv
module mute_uart_rx #(
   parameter int unsigned OSR         = 16,
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned IDLE_BITS   = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       os_tick,
   input  logic       rxd,
   input  logic [1:0] reg_addr,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq
);
   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("OSR must be even and at least 4");
      end
      if (DATA_BITS < 2 || DATA_BITS > muterx_pkg::REG_W) begin : g_bad_width
         $error("DATA_BITS must lie between 2 and the register width");
      end
      if (IDLE_BITS < 2) begin : g_bad_idle
         $error("IDLE_BITS must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic                 line, rx_idle, mark_evt, frame_done, stop_ok, idle_evt;
   logic [DATA_BITS-1:0] frame_data, data_q;
   logic                 mute, rx_en, ie, ready, ferr, hw_clr, hw_wake;

   muterx_frame #(.OSR(OSR), .DATA_BITS(DATA_BITS), .SYNC_STAGES(SYNC_STAGES)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .enable(rx_en), .rxd(rxd),
      .line(line), .rx_idle(rx_idle), .mark_evt(mark_evt),
      .frame_done(frame_done), .stop_ok(stop_ok), .data(frame_data)
   );

   muterx_idle #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .enable(rx_en),
      .line(line), .rx_idle(rx_idle), .wake(idle_evt)
   );

   muterx_regs #(.DATA_BITS(DATA_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr), .rd_en(reg_rd),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .frame_done(frame_done), .frame_stop_ok(stop_ok), .frame_data(frame_data),
      .mark_evt(mark_evt), .idle_evt(idle_evt),
      .mute(mute), .rx_en(rx_en), .ie(ie), .ready(ready), .ferr(ferr),
      .hw_clr(hw_clr), .hw_wake(hw_wake), .data_q(data_q)
   );

   assign irq = ready && ie;
endmodule

// File: rtl/mute_uart_rx_chk.sv
module mute_uart_rx_chk #(
   parameter int unsigned DATA_BITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           reg_addr,
   input logic                 reg_wr,
   input logic                 reg_rd,
   input logic [7:0]           reg_wdata,
   input logic                 frame_done,
   input logic                 mute,
   input logic                 ready,
   input logic                 ferr,
   input logic                 hw_clr,
   input logic                 hw_wake,
   input logic [DATA_BITS-1:0] data_q
);
   import muterx_pkg::*;

   // R5
   muted_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && mute && !(reg_rd && reg_addr == ADR_DATA)) |=> ($stable(ready) && $stable(data_q)));

   // R2
   accept_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !mute) |=> ready);

   // R3
   read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADR_DATA && !frame_done) |=> !ready);

   // R7
   mute_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mute) && !$past(reg_wr && reg_addr == ADR_CTRL)) |-> $past(hw_wake));

   // R9
   rearm_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_CTRL && reg_wdata[CB_MUTE] && hw_clr && !mute) |=> !mute);

   // R4
   ferr_moves_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ferr) |-> $past(frame_done && !mute));
endmodule

bind mute_uart_rx mute_uart_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_wdata(reg_wdata), .frame_done(frame_done), .mute(mute), .ready(ready),
   .ferr(ferr), .hw_clr(hw_clr), .hw_wake(hw_wake), .data_q(data_q)
);

// File: tb/mute_uart_rx_test.sv
module mute_uart_rx_test;
   localparam int BIT_CLK = 64;   // 16 ticks of 4 clocks
   localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
   localparam logic [7:0] C_MUTE = 8'h01, C_WADDR = 8'h02, C_RXEN = 8'h04,
                          C_IE = 8'h08, C_TXEN = 8'h10, C_BRK = 8'h20;

   logic       clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq;

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   mute_uart_rx uut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   always #2 clk = ~clk;

   initial begin
      forever begin
         repeat (3) @(posedge clk);
         os_tick <= 1'b1;
         @(posedge clk);
         os_tick <= 1'b0;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic idle_bits(input int n);
      repeat (n * BIT_CLK) @(negedge clk);
   endtask

   // drive one frame; queue the byte when it is expected to be accepted
   task automatic send_frame(input logic [7:0] b, input bit good_stop,
                             input int gap, input bit expect_rx, input string req);
      if (expect_rx) begin
         exp_q.push_back(b);
         tag_q.push_back(req);
      end
      @(negedge clk);
      rxd = 1'b0;
      idle_bits(1);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         idle_bits(1);
      end
      if (good_stop) begin
         rxd = 1'b1;
         idle_bits(1);
      end else begin
         rxd = 1'b0;
         repeat (BIT_CLK / 2 + 8) @(negedge clk);
         rxd = 1'b1;
         repeat (BIT_CLK / 2 - 8) @(negedge clk);
      end
      idle_bits(gap);
      if (expect_rx) check({req, " byte taken"}, exp_q.size(), 0);
   endtask

   // scoreboard monitor: drains the data register on every interrupt
   initial begin
      logic [7:0] got;
      string t;
      forever begin
         @(negedge clk);
         if (irq === 1'b1 && rst_n) begin
            bus_read(A_DATA, got);
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R5: unexpected byte actual %0h expected none", got);
            end else begin
               t = tag_q.pop_front();
               check({t, " data"}, got, exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      bus_read(A_CTRL, v); check("R11 ctrl", v, 8'h00);
      bus_read(A_STAT, v); check("R11 stat", v, 8'h00);
      check("R11 irq", irq, 1'b0);

      // R2 plain reception
      bus_write(A_CTRL, C_RXEN | C_IE | C_WADDR);
      idle_bits(2);
      send_frame(8'h35, 1, 2, 1, "R2");
      send_frame(8'hA7, 1, 2, 1, "R2");
      bus_read(A_STAT, v); check("R4 ferr clear", v, 8'h00);

      // R1 short glitch ignored
      @(negedge clk); rxd = 1'b0;
      repeat (16) @(negedge clk); rxd = 1'b1;
      idle_bits(2);
      send_frame(8'h5C, 1, 2, 1, "R1");

      // R4 framing error, R3 ready cleared by data read
      send_frame(8'h3A, 0, 2, 1, "R4");
      bus_read(A_STAT, v); check("R4/R3 stat after bad stop", v, 8'h02);
      send_frame(8'h11, 1, 2, 1, "R4");
      bus_read(A_STAT, v); check("R4 stat after good stop", v, 8'h00);

      // R5 mute, R7 address-mark wake
      bus_write(A_CTRL, C_RXEN | C_IE | C_WADDR | C_MUTE);
      bus_read(A_CTRL, v); check("R5 mute set", v, 8'h0F);
      send_frame(8'h12, 1, 2, 0, "R7");
      check("R5 irq after muted frame", irq, 1'b0);
      bus_read(A_STAT, v); check("R5 stat after muted frame", v, 8'h00);
      send_frame(8'h93, 1, 2, 1, "R7");

      // R9 stale read-modify-write cannot re-arm
      bus_write(A_CTRL, C_RXEN | C_IE | C_WADDR | C_MUTE);
      bus_read(A_CTRL, v); check("R9 mute blocked", v, 8'h0E);
      send_frame(8'h44, 1, 2, 1, "R9");
      bus_write(A_CTRL, C_RXEN | C_IE | C_WADDR | C_MUTE);
      bus_read(A_CTRL, v); check("R9 mute after read", v, 8'h0F);
      send_frame(8'h22, 1, 2, 0, "R9");
      bus_read(A_STAT, v); check("R9 rearmed drop", v, 8'h00);

      // R6 software leaves mute
      bus_write(A_CTRL, C_RXEN | C_IE | C_WADDR);
      bus_read(A_CTRL, v); check("R6 mute cleared", v, 8'h0E);
      send_frame(8'h7E, 1, 2, 1, "R6");

      // R10 receiver disabled
      bus_write(A_CTRL, C_IE);
      send_frame(8'h55, 1, 2, 0, "R10");
      bus_read(A_STAT, v); check("R10 stat", v, 8'h00);
      check("R10 irq", irq, 1'b0);

      // R8 idle-line wake
      bus_write(A_CTRL, C_RXEN | C_IE | C_MUTE);
      send_frame(8'hC5, 1, 4, 0, "R8");
      send_frame(8'h21, 1, 2, 0, "R8");
      bus_read(A_CTRL, v); check("R8 still muted", v, 8'h0D);
      bus_read(A_STAT, v); check("R8 nothing taken", v, 8'h00);
      idle_bits(12);
      bus_read(A_CTRL, v); check("R8 woke on idle", v, 8'h0C);
      send_frame(8'h66, 1, 2, 1, "R8");

      // R12 transmit enable and break bits
      bus_write(A_CTRL, C_RXEN | C_IE | C_WADDR | C_TXEN | C_BRK);
      bus_read(A_CTRL, v); check("R12 readback", v, 8'h3E);
      send_frame(8'h0F, 1, 2, 1, "R12");

      check("R2 queue drained", exp_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule